// File: doc/BRIEF.md
# Host DMA Sub-Block Sequencer

This block generates buffer addresses for moving decoded disc data from a segmented buffer memory to the host. The buffer is split into segments of a fixed size. Within each segment the sequencer gathers bytes from a short, programmable list of sub-blocks. Each sub-block is an offset into the segment plus a length. A channel field selects how many list entries are active. One buffer address is produced for each accepted host byte strobe.

Two counters gate the transfer. The running byte count stops the flow at a firmware-chosen byte boundary, and a sticky interrupt then asks firmware to reload it. The segment count limits how many segments are walked. At the end of each segment the sequencer either steps to the following segment number or, if the reload flag is armed, takes a prepared next segment and next segment count. A byte-wide register port holds all pointers. The live pointers read back as transfer status.

Register map (byte addresses): 0x00/0x01 current segment low/high, 0x02 segment count, 0x03 control (bits [CH_W-1:0] channel field, bit 7 reload flag), 0x04/0x05 next segment low/high, 0x06 next segment count, 0x07 status (bit 0 interrupt, write 1 to clear), 0x08/0x09 byte offset low/high, 0x0A/0x0B byte count low/high, and for pair i the bytes at 0x10+4i to 0x13+4i hold offset low, offset high, length low and length high.

Top module: `hdma_seq`

## Requirements
- R1: A strobe is accepted (hst_ack=1) only when the byte count and the segment count are both non-zero and no register write is presented in that cycle. xfer_ok shows the two-count condition.
- R2: While hst_ack is high, buf_addr equals current segment × SEG_BYTES + byte offset. Each accepted strobe advances the offset by one and lowers the byte count by one.
- R3: With channel field value C, pairs 0 to C are walked in order within each segment. Each pair supplies exactly its length in bytes, starting at its own offset.
- R4: After the last enabled pair of a segment, if the reload flag (control bit 7) is clear, the current segment increments by one, the segment count decrements by one, and the walk restarts at pair 0.
- R5: After the last enabled pair, if the reload flag is set, the next segment and next segment count are copied into the current registers in that same cycle, and the flag clears.
- R6: The interrupt (status bit 0) is set when an accepted strobe takes the byte count from 1 to 0. It stays set until firmware writes 1 to status bit 0.
- R7: A firmware write that leaves the byte count at zero does not set the interrupt.
- R8: Every register reads back at its address. The current segment, byte offset, byte count and segment count show live transfer state between strobes.
- R9: A write to either byte of the current segment rewinds the walk to pair 0: the offset is loaded from pair 0 and the remaining length from pair 0.
- R10: After reset, every register reads zero, xfer_ok is 0 and the interrupt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hst_strobe | input | 1 | Host requests one byte |
| hst_ack | output | 1 | Strobe accepted this cycle |
| xfer_ok | output | 1 | Both counts non-zero |
| buf_addr | output | ADDR_W | Buffer address of the byte being moved |
| irq | output | 1 | Byte-count-exhausted interrupt |

## Verification
The byte count can run out on the very last byte of a segment while the reload flag is armed. In that one cycle the interrupt is set and the prepared next segment is chained in. The bench sets the byte count to exactly one segment's worth of bytes and arms the reload. After the final strobe it reads back the current segment, the segment count, the cleared reload flag and the interrupt, and expects all four to have changed together. Sweeps over every channel field value and mid-segment stops around the byte count supply the surrounding context.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  localparam int PTR_W  = 16;
  localparam int SCNT_W = 8;
  localparam int RA_W   = 6;

  localparam logic [RA_W-1:0] RA_CSEG_L = 6'h00;
  localparam logic [RA_W-1:0] RA_CSEG_H = 6'h01;
  localparam logic [RA_W-1:0] RA_SCNT   = 6'h02;
  localparam logic [RA_W-1:0] RA_CTRL   = 6'h03;
  localparam logic [RA_W-1:0] RA_NSEG_L = 6'h04;
  localparam logic [RA_W-1:0] RA_NSEG_H = 6'h05;
  localparam logic [RA_W-1:0] RA_NSCNT  = 6'h06;
  localparam logic [RA_W-1:0] RA_STAT   = 6'h07;
  localparam logic [RA_W-1:0] RA_BOFF_L = 6'h08;
  localparam logic [RA_W-1:0] RA_BOFF_H = 6'h09;
  localparam logic [RA_W-1:0] RA_BCNT_L = 6'h0A;
  localparam logic [RA_W-1:0] RA_BCNT_H = 6'h0B;
  localparam logic [RA_W-1:0] RA_PAIR0  = 6'h10;
  localparam int CTRL_RELOAD_BIT = 7;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    logic            we;
    logic [RA_W-1:0] addr;
    logic [7:0]      data;
  } regwr_t;

  function automatic ptr_t put_byte(ptr_t v, logic hi, logic [7:0] b);
    ptr_t r;
    r = v;
    if (hi) r[PTR_W-1:8] = b;
    else    r[7:0] = b;
    return r;
  endfunction
endpackage

// File: rtl/hdma_rst_sync.sv
module hdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hdma_regs.sv
module hdma_regs
  import hdma_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  regwr_t                            wr_i,
  input  logic                              reload_taken_i,
  output logic [(1<<CH_W)-1:0][PTR_W-1:0]   off_o,
  output logic [(1<<CH_W)-1:0][PTR_W-1:0]   len_o,
  output logic [CH_W-1:0]                   chan_o,
  output logic                              reload_o,
  output logic [PTR_W-1:0]                  nseg_o,
  output logic [SCNT_W-1:0]                 nscnt_o
);
  localparam int NPAIR = 1 << CH_W;

  // sub-block list, one register set per pair
  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    localparam logic [RA_W-1:0] A0 = RA_W'(int'(RA_PAIR0) + 4 * i);
    logic [PTR_W-1:0] off_q, off_d, len_q, len_d;
    logic             en;

    always_comb begin
      off_d = off_q;
      len_d = len_q;
      en    = 1'b0;
      if (wr_i.we) begin
        if (wr_i.addr == A0) begin
          off_d = put_byte(off_q, 1'b0, wr_i.data); en = 1'b1;
        end
        if (wr_i.addr == A0 + RA_W'(1)) begin
          off_d = put_byte(off_q, 1'b1, wr_i.data); en = 1'b1;
        end
        if (wr_i.addr == A0 + RA_W'(2)) begin
          len_d = put_byte(len_q, 1'b0, wr_i.data); en = 1'b1;
        end
        if (wr_i.addr == A0 + RA_W'(3)) begin
          len_d = put_byte(len_q, 1'b1, wr_i.data); en = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q <= '0;
        len_q <= '0;
      end else if (en) begin
        off_q <= off_d;
        len_q <= len_d;
      end
    end

    assign off_o[i] = off_q;
    assign len_o[i] = len_q;
  end

  // control and chaining registers
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              rel_q, rel_d;
  logic [PTR_W-1:0]  nseg_q, nseg_d;
  logic [SCNT_W-1:0] nscnt_q, nscnt_d;
  logic              ctl_en;

  always_comb begin
    chan_d  = chan_q;
    rel_d   = rel_q;
    nseg_d  = nseg_q;
    nscnt_d = nscnt_q;
    ctl_en  = 1'b0;
    if (reload_taken_i) begin
      rel_d  = 1'b0;
      ctl_en = 1'b1;
    end
    if (wr_i.we) begin
      unique case (wr_i.addr)
        RA_CTRL: begin
          chan_d = wr_i.data[CH_W-1:0];
          rel_d  = wr_i.data[CTRL_RELOAD_BIT];
          ctl_en = 1'b1;
        end
        RA_NSEG_L: begin nseg_d = put_byte(nseg_q, 1'b0, wr_i.data); ctl_en = 1'b1; end
        RA_NSEG_H: begin nseg_d = put_byte(nseg_q, 1'b1, wr_i.data); ctl_en = 1'b1; end
        RA_NSCNT:  begin nscnt_d = wr_i.data; ctl_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      rel_q   <= 1'b0;
      nseg_q  <= '0;
      nscnt_q <= '0;
    end else if (ctl_en) begin
      chan_q  <= chan_d;
      rel_q   <= rel_d;
      nseg_q  <= nseg_d;
      nscnt_q <= nscnt_d;
    end
  end

  assign chan_o   = chan_q;
  assign reload_o = rel_q;
  assign nseg_o   = nseg_q;
  assign nscnt_o  = nscnt_q;

  AST_RELOAD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reload_taken_i && !wr_i.we |=> !reload_o) else $error("reload flag kept"); // R5
endmodule

// File: rtl/hdma_walk.sv
module hdma_walk
  import hdma_pkg::*;
#(
  parameter int CH_W      = 2,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 2352
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  regwr_t                            wr_i,
  input  logic                              strobe_i,
  input  logic [(1<<CH_W)-1:0][PTR_W-1:0]   off_i,
  input  logic [(1<<CH_W)-1:0][PTR_W-1:0]   len_i,
  input  logic [CH_W-1:0]                   chan_i,
  input  logic                              reload_i,
  input  logic [PTR_W-1:0]                  nseg_i,
  input  logic [SCNT_W-1:0]                 nscnt_i,
  output logic [PTR_W-1:0]                  cseg_o,
  output logic [SCNT_W-1:0]                 scnt_o,
  output logic [PTR_W-1:0]                  boff_o,
  output logic [PTR_W-1:0]                  bcnt_o,
  output logic                              xfer_ok_o,
  output logic                              ack_o,
  output logic [ADDR_W-1:0]                 buf_addr_o,
  output logic                              reload_taken_o,
  output logic                              zero_hit_o
);
  logic [PTR_W-1:0]  cseg_q, cseg_d, boff_q, boff_d, bcnt_q, bcnt_d, rem_q, rem_d;
  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic [CH_W-1:0]   pidx_q, pidx_d, pnext;
  logic              upd, pair_done, last_pair, rewind;

  assign xfer_ok_o  = (bcnt_q != '0) && (scnt_q != '0);
  assign ack_o      = strobe_i && xfer_ok_o && !wr_i.we;
  assign buf_addr_o = ADDR_W'(cseg_q) * ADDR_W'(SEG_BYTES) + ADDR_W'(boff_q);

  assign pnext      = pidx_q + CH_W'(1);
  assign pair_done  = ack_o && (rem_q <= PTR_W'(1));
  assign last_pair  = !(pidx_q < chan_i);
  assign zero_hit_o = ack_o && (bcnt_q == PTR_W'(1));
  assign reload_taken_o = pair_done && last_pair && reload_i;
  assign upd        = ack_o || wr_i.we;

  always_comb begin
    cseg_d = cseg_q;
    scnt_d = scnt_q;
    boff_d = boff_q;
    bcnt_d = bcnt_q;
    rem_d  = rem_q;
    pidx_d = pidx_q;
    rewind = 1'b0;

    if (ack_o) begin
      boff_d = boff_q + PTR_W'(1);
      rem_d  = rem_q - PTR_W'(1);
      bcnt_d = bcnt_q - PTR_W'(1);
      if (pair_done) begin
        if (!last_pair) begin
          pidx_d = pnext;
          boff_d = off_i[pnext];
          rem_d  = len_i[pnext];
        end else begin
          rewind = 1'b1;
          if (reload_i) begin
            cseg_d = nseg_i;
            scnt_d = nscnt_i;
          end else begin
            cseg_d = cseg_q + PTR_W'(1);
            scnt_d = scnt_q - SCNT_W'(1);
          end
        end
      end
    end

    if (wr_i.we) begin
      unique case (wr_i.addr)
        RA_CSEG_L: begin cseg_d = put_byte(cseg_q, 1'b0, wr_i.data); rewind = 1'b1; end
        RA_CSEG_H: begin cseg_d = put_byte(cseg_q, 1'b1, wr_i.data); rewind = 1'b1; end
        RA_SCNT:   scnt_d = wr_i.data;
        RA_BCNT_L: bcnt_d = put_byte(bcnt_q, 1'b0, wr_i.data);
        RA_BCNT_H: bcnt_d = put_byte(bcnt_q, 1'b1, wr_i.data);
        default: ;
      endcase
    end

    if (rewind) begin
      pidx_d = '0;
      boff_d = off_i[0];
      rem_d  = len_i[0];
    end

    if (wr_i.we && wr_i.addr == RA_BOFF_L) boff_d = put_byte(boff_q, 1'b0, wr_i.data);
    if (wr_i.we && wr_i.addr == RA_BOFF_H) boff_d = put_byte(boff_q, 1'b1, wr_i.data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cseg_q <= '0;
      scnt_q <= '0;
      boff_q <= '0;
      bcnt_q <= '0;
      rem_q  <= '0;
      pidx_q <= '0;
    end else if (upd) begin
      cseg_q <= cseg_d;
      scnt_q <= scnt_d;
      boff_q <= boff_d;
      bcnt_q <= bcnt_d;
      rem_q  <= rem_d;
      pidx_q <= pidx_d;
    end
  end

  assign cseg_o = cseg_q;
  assign scnt_o = scnt_q;
  assign boff_o = boff_q;
  assign bcnt_o = bcnt_q;

  AST_ACK_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (bcnt_q + PTR_W'(1) == $past(bcnt_q))) else $error("byte count step"); // R2
  AST_SCNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o && !(wr_i.we && wr_i.addr == RA_SCNT) |=> $stable(scnt_q)) else $error("segment count moved"); // R4
  AST_CHAIN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    reload_taken_o |=> (cseg_q == $past(nseg_i)) && (scnt_q == $past(nscnt_i))) else $error("chain copy"); // R5
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt_q == '0) |-> !ack_o) else $error("ack at zero count"); // R1
endmodule

// File: rtl/hdma_irq.sv
module hdma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_hit_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q, irq_d, irq_en;

  always_comb begin
    irq_en = zero_hit_i || clr_i;
    irq_d  = zero_hit_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit_i |=> irq_o) else $error("irq not set"); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !clr_i |=> irq_o) else $error("irq dropped"); // R6
  AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o && !zero_hit_i |=> !irq_o) else $error("irq without cause"); // R7
endmodule

// File: rtl/hdma_seq.sv
module hdma_seq
  import hdma_pkg::*;
#(
  parameter int CH_W      = 2,
  parameter int ADDR_W    = 32,
  parameter int SEG_BYTES = 2352
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              hst_strobe,
  output logic              hst_ack,
  output logic              xfer_ok,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              irq
);
  localparam int NPAIR = 1 << CH_W;

  logic                         rst_n_s;
  regwr_t                       wr;
  logic [NPAIR-1:0][PTR_W-1:0]  off, len;
  logic [CH_W-1:0]              chan;
  logic                         reload, reload_taken, zero_hit, irq_clr;
  logic [PTR_W-1:0]             nseg, cseg, boff, bcnt;
  logic [SCNT_W-1:0]            nscnt, scnt;

  assign wr.we   = reg_we;
  assign wr.addr = reg_addr;
  assign wr.data = reg_wdata;
  assign irq_clr = reg_we && (reg_addr == RA_STAT) && reg_wdata[0];

  hdma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  hdma_regs #(.CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_i(wr), .reload_taken_i(reload_taken),
    .off_o(off), .len_o(len), .chan_o(chan), .reload_o(reload),
    .nseg_o(nseg), .nscnt_o(nscnt)
  );

  hdma_walk #(.CH_W(CH_W), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n_s), .wr_i(wr), .strobe_i(hst_strobe),
    .off_i(off), .len_i(len), .chan_i(chan), .reload_i(reload),
    .nseg_i(nseg), .nscnt_i(nscnt),
    .cseg_o(cseg), .scnt_o(scnt), .boff_o(boff), .bcnt_o(bcnt),
    .xfer_ok_o(xfer_ok), .ack_o(hst_ack), .buf_addr_o(buf_addr),
    .reload_taken_o(reload_taken), .zero_hit_o(zero_hit)
  );

  hdma_irq u_irq (
    .clk(clk), .rst_n(rst_n_s), .zero_hit_i(zero_hit), .clr_i(irq_clr), .irq_o(irq)
  );

  // register read-back, live pointers included
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CSEG_L: reg_rdata = cseg[7:0];
      RA_CSEG_H: reg_rdata = cseg[PTR_W-1:8];
      RA_SCNT:   reg_rdata = scnt;
      RA_CTRL: begin
        reg_rdata[CH_W-1:0]        = chan;
        reg_rdata[CTRL_RELOAD_BIT] = reload;
      end
      RA_NSEG_L: reg_rdata = nseg[7:0];
      RA_NSEG_H: reg_rdata = nseg[PTR_W-1:8];
      RA_NSCNT:  reg_rdata = nscnt;
      RA_STAT:   reg_rdata[0] = irq;
      RA_BOFF_L: reg_rdata = boff[7:0];
      RA_BOFF_H: reg_rdata = boff[PTR_W-1:8];
      RA_BCNT_L: reg_rdata = bcnt[7:0];
      RA_BCNT_H: reg_rdata = bcnt[PTR_W-1:8];
      default: begin
        for (int i = 0; i < NPAIR; i++) begin
          if (reg_addr == RA_W'(int'(RA_PAIR0) + 4 * i))     reg_rdata = off[i][7:0];
          if (reg_addr == RA_W'(int'(RA_PAIR0) + 4 * i + 1)) reg_rdata = off[i][PTR_W-1:8];
          if (reg_addr == RA_W'(int'(RA_PAIR0) + 4 * i + 2)) reg_rdata = len[i][7:0];
          if (reg_addr == RA_W'(int'(RA_PAIR0) + 4 * i + 3)) reg_rdata = len[i][PTR_W-1:8];
        end
      end
    endcase
  end
endmodule

// File: tb/sim_hdma_seq.sv
module sim_hdma_seq;
  localparam int SEGB   = 64;
  localparam int ADDR_W = 20;

  logic              clk, rst_n, reg_we, hst_strobe, hst_ack, xfer_ok, irq;
  logic [5:0]        reg_addr;
  logic [7:0]        reg_wdata, reg_rdata;
  logic [ADDR_W-1:0] buf_addr;

  int n_chk = 0;
  int n_fail = 0;
  int offs[4];
  int lens[4];

  hdma_seq #(.CH_W(2), .ADDR_W(ADDR_W), .SEG_BYTES(SEGB)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hst_strobe(hst_strobe),
    .hst_ack(hst_ack), .xfer_ok(xfer_ok), .buf_addr(buf_addr), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr16(input int a, input int v);
    wr(a, v & 255);
    wr(a + 1, (v >> 8) & 255);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic rd16(input int a, output int v);
    int lo, hi;
    rd(a, lo);
    rd(a + 1, hi);
    v = lo + (hi << 8);
  endtask

  task automatic strobe_exp(input string req, input int exp_addr);
    @(negedge clk);
    hst_strobe = 1'b1;
    #1;
    chk(req, hst_ack, 1);
    chk(req, buf_addr, exp_addr);
  endtask

  task automatic strobe_stop;
    @(negedge clk);
    hst_strobe = 1'b0;
  endtask

  task automatic load_pairs;
    for (int p = 0; p < 4; p++) begin
      wr16(16 + 4 * p, offs[p]);
      wr16(18 + 4 * p, lens[p]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; hst_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 xfer_ok", xfer_ok, 0);
    chk("R10 irq", irq, 0);
    for (int a = 0; a < 32; a++) begin
      rd(a, v);
      chk("R10 reg", v, 0);
    end

    // R8: next-segment registers read back
    wr16(4, 16'h1234);
    rd16(4, v);
    chk("R8 next segment", v, 16'h1234);

    // R3 R4: sweep channel field, two segments each, no reload
    for (int c = 0; c < 4; c++) begin
      int s0, tot;
      tot = 0;
      for (int p = 0; p < 4; p++) begin
        offs[p] = p * 11 + c;
        lens[p] = p + 2;
        if (p <= c) tot += lens[p];
      end
      load_pairs();
      wr(3, c);
      s0 = 2 + c;
      wr16(0, s0);
      wr(2, 2);
      wr16(10, 2 * tot);
      wr(7, 1);
      for (int s = 0; s < 2; s++)
        for (int p = 0; p <= c; p++)
          for (int k = 0; k < lens[p]; k++)
            strobe_exp("R3", (s0 + s) * SEGB + offs[p] + k);
      strobe_stop();
      #1;
      chk("R1 stop", xfer_ok, 0);
      chk("R6 irq", irq, 1);
      rd16(0, v); chk("R4 segment step", v, s0 + 2);
      rd(2, v);   chk("R4 segment count", v, 0);
      rd16(8, v); chk("R4 rewind offset", v, offs[0]);
    end

    // R6: write-1-to-clear
    wr(7, 0);
    #1 chk("R6 write0 keeps", irq, 1);
    wr(7, 1);
    #1 chk("R6 clear", irq, 0);

    // R1 R8: byte count stops mid segment, then resumes from live offset
    offs[0] = 3; lens[0] = 4; offs[1] = 40; lens[1] = 5;
    load_pairs();
    wr(3, 1);
    wr16(0, 10);
    wr(2, 3);
    wr16(10, 5);
    for (int k = 0; k < 4; k++) strobe_exp("R2", 10 * SEGB + 3 + k);
    strobe_exp("R3", 10 * SEGB + 40);
    @(negedge clk);
    #1 chk("R1 byte count exhausted", hst_ack, 0);
    strobe_stop();
    #1 chk("R6 irq mid", irq, 1);
    rd16(8, v);  chk("R8 live offset", v, 41);
    rd16(10, v); chk("R8 live count", v, 0);
    rd16(0, v);  chk("R8 live segment", v, 10);
    wr(7, 1);
    wr16(10, 13);
    for (int k = 0; k < 4; k++) strobe_exp("R2 resume", 10 * SEGB + 41 + k);
    for (int k = 0; k < 4; k++) strobe_exp("R4 next seg", 11 * SEGB + 3 + k);
    for (int k = 0; k < 5; k++) strobe_exp("R3 pair1", 11 * SEGB + 40 + k);
    strobe_stop();
    #1 chk("R6 irq again", irq, 1);
    rd(2, v); chk("R4 count", v, 1);

    // R7: zero byte count written by firmware
    wr(7, 1);
    wr16(10, 0);
    #1 chk("R7 no irq", irq, 0);
    wr16(10, 7);
    wr16(10, 0);
    #1 chk("R7 no irq after reload to zero", irq, 0);
    chk("R1 xfer_ok zero", xfer_ok, 0);

    // R1: write in the same cycle blocks the strobe
    wr16(10, 5);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'd6; reg_wdata = 8'd9; hst_strobe = 1'b1;
    #1 chk("R1 write blocks ack", hst_ack, 0);
    @(negedge clk);
    reg_we = 1'b0; hst_strobe = 1'b0;
    rd16(10, v); chk("R1 count unchanged", v, 5);

    // R9: write to current segment rewinds to pair 0
    strobe_exp("R9 pre", 12 * SEGB + 3);
    strobe_exp("R9 pre", 12 * SEGB + 4);
    strobe_stop();
    wr(0, 20);
    strobe_exp("R9 rewind", 20 * SEGB + 3);
    strobe_stop();

    // R5 R6: last byte of segment exhausts count while reload is armed
    wr(7, 1);
    wr16(0, 30);
    wr(2, 1);
    wr16(4, 50);
    wr(6, 4);
    wr(3, 8'h81);
    wr16(10, 9);
    for (int k = 0; k < 4; k++) strobe_exp("R5", 30 * SEGB + 3 + k);
    for (int k = 0; k < 5; k++) strobe_exp("R5", 30 * SEGB + 40 + k);
    strobe_stop();
    #1 chk("R6 coincident irq", irq, 1);
    rd16(0, v); chk("R5 segment copied", v, 50);
    rd(2, v);   chk("R5 count copied", v, 4);
    rd(3, v);   chk("R5 flag cleared", v, 1);
    rd16(8, v); chk("R5 offset rewound", v, 3);

    // R4 after chain: continue without reload
    wr(7, 1);
    wr16(10, 9);
    for (int k = 0; k < 4; k++) strobe_exp("R4 chained", 50 * SEGB + 3 + k);
    for (int k = 0; k < 5; k++) strobe_exp("R4 chained", 50 * SEGB + 40 + k);
    strobe_stop();
    rd16(0, v); chk("R4 step after chain", v, 51);
    rd(2, v);   chk("R4 count after chain", v, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule